// File: doc/BRIEF.md
# Data Cache Control and Line-Lock Unit

This block controls a small two-way set-associative data cache through two software-visible registers. One holds a command and status word; the other holds an address. Writing a command code can switch caching on, switch it off, pin the line that holds the stored address, or drop every line that is not pinned. The unit keeps the tag, valid, lock and replacement state for 16 sets of 16-byte lines. It reports on every access whether the access hits or must go to the bus as an uncached single-beat transfer. Line data is held elsewhere. This unit only tracks line state and fetches the beats.

A cacheable miss, or a pin request that misses, starts a line fill on a request/grant/valid memory port. The fill fetches four 32-bit beats and then installs the line. For a pin request the line is also marked locked. Locked lines are never chosen for replacement and survive the invalidate command. Error flags stay set until software reads the status word. Software can therefore issue a batch of pin requests and check the result once. A machine-check error input forces caching off.

Top module: `dcache_ctl`

## Requirements
- R1: After reset the status word reads 0: caching off, not busy, no error flags. Status bit 0 is enable, bit 1 is busy, bit 2 is the type-1 error flag and bit 3 is the type-2 error flag. No memory request is pending after reset.
- R2: A status write (reg_sel=0) with command code 0x2 in bits 3:0 sets the enable bit. Code 0x4 clears it. Neither code sets an error flag, and line state is kept across both.
- R3: While caching is off, every access reports acc_inhibit=1 and acc_hit=0, whatever lines are stored, and no fill starts.
- R4: A pulse on mce_type1 clears the enable bit and sets the type-1 error flag on the next clock edge.
- R5: Code 0x6 (pin) on a line that is already present locks it in the same cycle. No memory request is made and busy stays clear.
- R6: A cacheable miss, or a pin request that misses, raises mem_req with the line-aligned address. The request and address are held until mem_gnt. After four mem_rvalid beats the line hits; a pin fill also leaves it locked. Busy reads 1 while the fill runs.
- R7: A locked way is never replaced. A cacheable miss in a set whose two ways are both locked starts no fill.
- R8: A pin request that misses in a set whose two ways are both locked starts no fill and sets the type-2 flag.
- R9: An access with acc_zws=1 never hits, is reported inhibited and starts no fill. A pin request issued with lock_zws=1 starts no fill and sets the type-2 flag.
- R10: Code 0xC clears the valid state of every unlocked line and leaves locked lines hitting. Busy reads 1 while the sets are walked.
- R11: Error flags are sticky. A status read returns them and clears them, unless a new error is raised in that same cycle.
- R12: While busy, command writes and address-register writes are ignored. Undefined command codes are ignored at any time.
- R13: Victim choice takes an invalid unlocked way first, the lower way index winning. Otherwise it takes the only unlocked way. Otherwise it takes the least recently used way, where a hit or a fill makes the other way the next victim.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (a status read clears the error flags) |
| reg_sel | input | 1 | 0 selects the command/status word, 1 selects the address register |
| reg_wdata | input | 32 | Write data; command code in bits 3:0 |
| reg_rdata | output | 32 | Read data for the selected register |
| lock_zws | input | 1 | Address register decodes to a zero-wait-state region |
| mce_type1 | input | 1 | Type-1 error that raised a machine check |
| acc_valid | input | 1 | Data access presented this cycle |
| acc_line | input | 28 | Line address of the access |
| acc_zws | input | 1 | Access address decodes to a zero-wait-state region |
| acc_hit | output | 1 | Access hits a valid line while caching is on |
| acc_inhibit | output | 1 | Access must go to the bus as a single-beat uncached transfer |
| mem_req | output | 1 | Line fill request |
| mem_addr | output | 32 | Line-aligned fill address |
| mem_gnt | input | 1 | Fill request accepted |
| mem_rvalid | input | 1 | One fill beat returned |

## Verification
The assertions check on every cycle the properties that need no memory of earlier lines. These are: the off state and zero-wait-state accesses never produce a hit; a machine check turns caching off; a fill request holds its address until granted and only while busy; the type-2 flag stays set until a status read; and a command written while busy leaves the enable bit unchanged. The following depend on earlier stored state, so only the bench scenarios can show them: which way a miss evicts, that pinned lines survive invalidation and replacement, that a pin hit makes no bus request, and that fills land at the right address.

// File: rtl/dcl_pkg.sv
package dcl_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_DATA = 2'd2,
        ST_INV  = 2'd3
    } dcl_st_e;

    localparam logic [3:0] CMD_ENABLE  = 4'h2;
    localparam logic [3:0] CMD_DISABLE = 4'h4;
    localparam logic [3:0] CMD_LOCK    = 4'h6;
    localparam logic [3:0] CMD_INVAL   = 4'hC;
endpackage

// File: rtl/dcl_lookup.sv
module dcl_lookup #(
    parameter int TAG_W = 24,
    parameter int WAYS  = 2,
    localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic [WAYS-1:0]            vld,
    input  logic [WAYS-1:0][TAG_W-1:0] tags,
    input  logic [TAG_W-1:0]           tag,
    output logic                       hit,
    output logic [WAY_W-1:0]           way
);
    logic [WAYS-1:0] match;

    generate
        for (genvar g = 0; g < WAYS; g++) begin : g_cmp
            assign match[g] = vld[g] && (tags[g] == tag);
        end
    endgenerate

    always_comb begin
        way = '0;
        for (int i = 0; i < WAYS; i++) begin
            if (match[i]) way = WAY_W'(i);
        end
    end

    assign hit = |match;
endmodule

// File: rtl/dcl_victim.sv
module dcl_victim (
    input  logic [1:0] vld,
    input  logic [1:0] lck,
    input  logic       lru,
    output logic       all_locked,
    output logic       victim
);
    always_comb begin
        all_locked = &lck;
        if (!lck[0] && !vld[0])      victim = 1'b0;
        else if (!lck[1] && !vld[1]) victim = 1'b1;
        else if (lck[0])             victim = 1'b1;
        else if (lck[1])             victim = 1'b0;
        else                         victim = lru;
    end
endmodule

// File: rtl/dcache_ctl.sv
module dcache_ctl
    import dcl_pkg::*;
#(
    parameter int AW         = 32,
    parameter int SETS       = 16,
    parameter int LINE_BYTES = 16,
    parameter int BEAT_BYTES = 4,
    localparam int OFF_W  = $clog2(LINE_BYTES),
    localparam int SET_W  = $clog2(SETS),
    localparam int TAG_W  = AW - SET_W - OFF_W,
    localparam int BEATS  = LINE_BYTES / BEAT_BYTES,
    localparam int BEAT_W = (BEATS > 1) ? $clog2(BEATS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic              reg_sel,
    input  logic [AW-1:0]     reg_wdata,
    output logic [AW-1:0]     reg_rdata,
    input  logic              lock_zws,
    input  logic              mce_type1,
    input  logic              acc_valid,
    input  logic [AW-OFF_W-1:0] acc_line,
    input  logic              acc_zws,
    output logic              acc_hit,
    output logic              acc_inhibit,
    output logic              mem_req,
    output logic [AW-1:0]     mem_addr,
    input  logic              mem_gnt,
    input  logic              mem_rvalid
);
    typedef struct packed {
        dcl_st_e                          st;
        logic                             en;
        logic                             err1;
        logic                             err2;
        logic [AW-1:0]                    adr;
        logic [SET_W-1:0]                 idx;
        logic [TAG_W-1:0]                 ftag;
        logic                             fway;
        logic                             flock;
        logic [BEAT_W-1:0]                beat;
        logic [SETS-1:0][1:0]             vld;
        logic [SETS-1:0][1:0]             lck;
        logic [SETS-1:0]                  lru;
        logic [SETS-1:0][1:0][TAG_W-1:0]  tag;
    } state_t;

    state_t q, d;

    // access-side lookup
    logic [SET_W-1:0] a_set;
    logic [TAG_W-1:0] a_tag;
    logic             a_hit, a_way, a_vic, a_all_lck;
    assign a_set = acc_line[SET_W-1:0];
    assign a_tag = acc_line[AW-OFF_W-1 -: TAG_W];

    dcl_lookup #(.TAG_W(TAG_W), .WAYS(2)) u_acc_lk (
        .vld(q.vld[a_set]), .tags(q.tag[a_set]), .tag(a_tag),
        .hit(a_hit), .way(a_way)
    );
    dcl_victim u_acc_vic (
        .vld(q.vld[a_set]), .lck(q.lck[a_set]), .lru(q.lru[a_set]),
        .all_locked(a_all_lck), .victim(a_vic)
    );

    // command-side lookup on the address register
    logic [SET_W-1:0] c_set;
    logic [TAG_W-1:0] c_tag;
    logic             c_hit, c_way, c_vic, c_all_lck;
    assign c_set = q.adr[OFF_W +: SET_W];
    assign c_tag = q.adr[AW-1 -: TAG_W];

    dcl_lookup #(.TAG_W(TAG_W), .WAYS(2)) u_cmd_lk (
        .vld(q.vld[c_set]), .tags(q.tag[c_set]), .tag(c_tag),
        .hit(c_hit), .way(c_way)
    );
    dcl_victim u_cmd_vic (
        .vld(q.vld[c_set]), .lck(q.lck[c_set]), .lru(q.lru[c_set]),
        .all_locked(c_all_lck), .victim(c_vic)
    );

    logic cacheable, stat_en, stat_busy, stat_err1, stat_err2;
    assign cacheable = acc_valid && q.en && !acc_zws;
    assign stat_en   = q.en;
    assign stat_busy = (q.st != ST_IDLE);
    assign stat_err1 = q.err1;
    assign stat_err2 = q.err2;

    always_comb begin
        d = q;
        if (cacheable && a_hit) d.lru[a_set] = ~a_way;
        if (reg_rd && !reg_sel) begin
            d.err1 = 1'b0;
            d.err2 = 1'b0;
        end
        case (q.st)
            ST_IDLE: begin
                if (reg_wr && reg_sel) begin
                    d.adr = reg_wdata;
                end else if (reg_wr) begin
                    case (reg_wdata[3:0])
                        CMD_ENABLE:  d.en = 1'b1;
                        CMD_DISABLE: d.en = 1'b0;
                        CMD_LOCK: begin
                            if (lock_zws) begin
                                d.err2 = 1'b1;
                            end else if (c_hit) begin
                                d.lck[c_set][c_way] = 1'b1;
                                d.lru[c_set]        = ~c_way;
                            end else if (c_all_lck) begin
                                d.err2 = 1'b1;
                            end else begin
                                d.st                = ST_REQ;
                                d.idx               = c_set;
                                d.ftag              = c_tag;
                                d.fway              = c_vic;
                                d.flock             = 1'b1;
                                d.beat              = '0;
                                d.vld[c_set][c_vic] = 1'b0;
                            end
                        end
                        CMD_INVAL: begin
                            d.st  = ST_INV;
                            d.idx = '0;
                        end
                        default: ;
                    endcase
                end else if (cacheable && !a_hit && !a_all_lck) begin
                    d.st                = ST_REQ;
                    d.idx               = a_set;
                    d.ftag              = a_tag;
                    d.fway              = a_vic;
                    d.flock             = 1'b0;
                    d.beat              = '0;
                    d.vld[a_set][a_vic] = 1'b0;
                end
            end
            ST_REQ: begin
                if (mem_gnt) d.st = ST_DATA;
            end
            ST_DATA: begin
                if (mem_rvalid) begin
                    d.beat = q.beat + 1'b1;
                    if (q.beat == BEAT_W'(BEATS - 1)) begin
                        d.vld[q.idx][q.fway] = 1'b1;
                        d.lck[q.idx][q.fway] = q.flock;
                        d.tag[q.idx][q.fway] = q.ftag;
                        d.lru[q.idx]         = ~q.fway;
                        d.st                 = ST_IDLE;
                    end
                end
            end
            ST_INV: begin
                for (int w = 0; w < 2; w++) begin
                    d.vld[q.idx][w] = q.vld[q.idx][w] & q.lck[q.idx][w];
                end
                d.idx = q.idx + 1'b1;
                if (q.idx == SET_W'(SETS - 1)) d.st = ST_IDLE;
            end
            default: d.st = ST_IDLE;
        endcase
        if (mce_type1) begin
            d.en   = 1'b0;
            d.err1 = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= ST_IDLE;
        end else begin
            q <= d;
        end
    end

    assign acc_hit     = cacheable && a_hit;
    assign acc_inhibit = !q.en || acc_zws;
    assign mem_req     = (q.st == ST_REQ);
    assign mem_addr    = {q.ftag, q.idx, {OFF_W{1'b0}}};
    assign reg_rdata   = reg_sel ? q.adr
                                 : {{(AW-4){1'b0}}, stat_err2, stat_err1, stat_busy, stat_en};
endmodule

// File: rtl/dcl_chk.sv
module dcl_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          mce_type1,
    input logic          reg_wr,
    input logic          reg_rd,
    input logic          reg_sel,
    input logic          acc_valid,
    input logic          acc_zws,
    input logic          acc_hit,
    input logic          acc_inhibit,
    input logic          mem_req,
    input logic          mem_gnt,
    input logic [AW-1:0] mem_addr,
    input logic          stat_en,
    input logic          stat_busy,
    input logic          stat_err2
);
    a_r4_mce_disables: assert property (@(posedge clk) disable iff (!rst_n)
        mce_type1 |=> !stat_en);

    a_r3_off_inhibits: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !stat_en) |-> (acc_inhibit && !acc_hit));

    a_r9_zws_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && acc_zws) |-> (acc_inhibit && !acc_hit));

    a_r6_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr)));

    a_r6_req_busy: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> stat_busy);

    a_r11_err2_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_err2 && !(reg_rd && !reg_sel)) |=> stat_err2);

    a_r12_busy_cmd_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_busy && reg_wr && !mce_type1) |=> (stat_en == $past(stat_en)));
endmodule

bind dcache_ctl dcl_chk #(.AW(AW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mce_type1  (mce_type1),
    .reg_wr     (reg_wr),
    .reg_rd     (reg_rd),
    .reg_sel    (reg_sel),
    .acc_valid  (acc_valid),
    .acc_zws    (acc_zws),
    .acc_hit    (acc_hit),
    .acc_inhibit(acc_inhibit),
    .mem_req    (mem_req),
    .mem_gnt    (mem_gnt),
    .mem_addr   (mem_addr),
    .stat_en    (stat_en),
    .stat_busy  (stat_busy),
    .stat_err2  (stat_err2)
);

// File: tb/dcache_ctl_bench.sv
module dcache_ctl_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0, reg_sel = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        lock_zws = 1'b0, mce_type1 = 1'b0;
    logic        acc_valid = 1'b0, acc_zws = 1'b0;
    logic [27:0] acc_line = '0;
    logic        acc_hit, acc_inhibit;
    logic        mem_req;
    logic [31:0] mem_addr;
    logic        mem_gnt = 1'b0, mem_rvalid = 1'b0;

    int checks = 0;
    int errors = 0;
    int fill_cnt = 0;
    logic [31:0] last_fill = '0;
    bit done = 1'b0;

    dcache_ctl u_dcache_ctl (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .lock_zws(lock_zws), .mce_type1(mce_type1), .acc_valid(acc_valid),
        .acc_line(acc_line), .acc_zws(acc_zws), .acc_hit(acc_hit),
        .acc_inhibit(acc_inhibit), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_gnt(mem_gnt), .mem_rvalid(mem_rvalid)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [31:0] la(input int t, input int s);
        return (32'(t) << 8) | (32'(s) << 4);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cmd(input logic [3:0] c, input logic zws);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = 1'b0; reg_wdata = 32'(c); lock_zws = zws;
        @(negedge clk);
        reg_wr = 1'b0; lock_zws = 1'b0;
    endtask

    task automatic wr_adr(input logic [31:0] a);
        @(negedge clk);
        reg_wr = 1'b1; reg_sel = 1'b1; reg_wdata = a;
        @(negedge clk);
        reg_wr = 1'b0; reg_sel = 1'b0;
    endtask

    task automatic rd(input logic sel, output logic [31:0] v);
        @(negedge clk);
        reg_rd = 1'b1; reg_sel = sel;
        #1 v = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0; reg_sel = 1'b0;
    endtask

    task automatic acc(input logic [31:0] a, input logic zws, output logic hit, output logic inh);
        @(negedge clk);
        acc_valid = 1'b1; acc_line = a[31:4]; acc_zws = zws;
        #1 hit = acc_hit; inh = acc_inhibit;
        @(negedge clk);
        acc_valid = 1'b0; acc_zws = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // memory responder: grant after two waiting cycles, then four beats
    initial begin
        forever begin
            @(negedge clk);
            if (mem_req) begin
                fill_cnt++;
                last_fill = mem_addr;
                repeat (2) begin
                    @(negedge clk);
                    if (!mem_req || mem_addr !== last_fill)
                        chk("R6 request held", {31'd0, mem_req}, 32'd1);
                end
                mem_gnt = 1'b1;
                @(negedge clk);
                mem_gnt = 1'b0;
                mem_rvalid = 1'b1;
                repeat (4) @(negedge clk);
                mem_rvalid = 1'b0;
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        logic h, inh;
        int f0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(1'b0, v); chk("R1 status after reset", v, 32'h0);
        chk("R1 no request", {31'd0, mem_req}, 32'd0);
        acc(la(1, 0), 1'b0, h, inh);
        chk("R3 off hit", {31'd0, h}, 32'd0);
        chk("R3 off inhibit", {31'd0, inh}, 32'd1);
        idle(10); chk("R3 off no fill", 32'(fill_cnt), 32'd0);

        // R2 enable
        cmd(4'h2, 1'b0);
        rd(1'b0, v); chk("R2 enable", v, 32'h1);

        // R6 sweep every set with a normal fill
        for (int s = 0; s < 16; s++) begin
            acc(la(1, s), 1'b0, h, inh);
            chk("R6 first miss", {30'd0, h, inh}, 32'd0);
            idle(10);
            chk("R6 fill count", 32'(fill_cnt), 32'(s + 1));
            chk("R6 fill address", last_fill, la(1, s));
            acc(la(1, s), 1'b0, h, inh);
            chk("R6 hit after fill", {31'd0, h}, 32'd1);
        end

        // R2 disable keeps state; R3 off path
        cmd(4'h4, 1'b0);
        rd(1'b0, v); chk("R2 disable", v, 32'h0);
        f0 = fill_cnt;
        acc(la(1, 0), 1'b0, h, inh);
        chk("R3 disabled inhibits", {30'd0, h, inh}, 32'd1);
        idle(10); chk("R3 disabled no fill", 32'(fill_cnt), 32'(f0));
        cmd(4'h2, 1'b0);
        acc(la(1, 0), 1'b0, h, inh);
        chk("R2 line kept", {30'd0, h, inh}, 32'd2);

        // R6/R5 pin miss then pin hit in set 3
        wr_adr(la(2, 3) | 32'h8);
        cmd(4'h6, 1'b0);
        idle(12);
        chk("R6 pin fill count", 32'(fill_cnt), 32'(f0 + 1));
        chk("R6 pin fill address", last_fill, la(2, 3));
        rd(1'b0, v); chk("R6 pin no error", v, 32'h1);
        wr_adr(la(1, 3));
        f0 = fill_cnt;
        cmd(4'h6, 1'b0);
        rd(1'b0, v); chk("R5 pin hit not busy", v, 32'h1);
        idle(10); chk("R5 pin hit no fill", 32'(fill_cnt), 32'(f0));

        // R8 both ways pinned, R11 sticky then cleared
        wr_adr(la(3, 3));
        cmd(4'h6, 1'b0);
        idle(6);
        chk("R8 no fill", 32'(fill_cnt), 32'(f0));
        rd(1'b0, v); chk("R8 err2 set", v, 32'h9);
        rd(1'b0, v); chk("R11 cleared by read", v, 32'h1);

        // R7 locked ways not replaced
        acc(la(3, 3), 1'b0, h, inh);
        chk("R7 miss", {31'd0, h}, 32'd0);
        idle(10); chk("R7 no fill", 32'(fill_cnt), 32'(f0));
        acc(la(1, 3), 1'b0, h, inh); chk("R7 tag1 kept", {31'd0, h}, 32'd1);
        acc(la(2, 3), 1'b0, h, inh); chk("R7 tag2 kept", {31'd0, h}, 32'd1);

        // R13 victim order in set 5
        acc(la(2, 5), 1'b0, h, inh); idle(10);
        acc(la(1, 5), 1'b0, h, inh); chk("R13 tag1 hit", {31'd0, h}, 32'd1);
        acc(la(2, 5), 1'b0, h, inh); chk("R13 invalid way used", {31'd0, h}, 32'd1);
        acc(la(1, 5), 1'b0, h, inh);
        acc(la(3, 5), 1'b0, h, inh); idle(10);
        acc(la(1, 5), 1'b0, h, inh); chk("R13 recent kept", {31'd0, h}, 32'd1);
        acc(la(3, 5), 1'b0, h, inh); chk("R13 new line", {31'd0, h}, 32'd1);
        acc(la(2, 5), 1'b0, h, inh); chk("R13 lru evicted", {31'd0, h}, 32'd0);
        idle(10);
        acc(la(1, 5), 1'b0, h, inh); chk("R13 lru evicted next", {31'd0, h}, 32'd0);
        idle(10);

        // R10 invalidate respects locks
        cmd(4'hC, 1'b0);
        rd(1'b0, v); chk("R10 busy", v, 32'h3);
        idle(20);
        rd(1'b0, v); chk("R10 done", v, 32'h1);
        acc(la(1, 3), 1'b0, h, inh); chk("R10 locked tag1", {31'd0, h}, 32'd1);
        acc(la(2, 3), 1'b0, h, inh); chk("R10 locked tag2", {31'd0, h}, 32'd1);
        for (int s = 0; s < 16; s++) begin
            if (s != 3) begin
                acc(la(1, s), 1'b0, h, inh);
                chk("R10 unlocked gone", {31'd0, h}, 32'd0);
                idle(10);
            end
        end

        // R12 writes ignored while busy, undefined code ignored
        f0 = fill_cnt;
        wr_adr(la(5, 7));
        cmd(4'h6, 1'b0);
        cmd(4'h4, 1'b0);
        wr_adr(la(9, 9));
        idle(12);
        rd(1'b0, v); chk("R12 disable ignored", v, 32'h1);
        rd(1'b1, v); chk("R12 address kept", v, la(5, 7));
        chk("R12 one fill", 32'(fill_cnt), 32'(f0 + 1));
        acc(la(5, 7), 1'b0, h, inh); chk("R6 pin line hits", {31'd0, h}, 32'd1);
        cmd(4'h7, 1'b0);
        idle(8);
        rd(1'b0, v); chk("R12 unknown code", v, 32'h1);
        chk("R12 unknown no fill", 32'(fill_cnt), 32'(f0 + 1));

        // R9 zero-wait-state
        f0 = fill_cnt;
        acc(la(1, 3), 1'b1, h, inh);
        chk("R9 zws access", {30'd0, h, inh}, 32'd1);
        acc(la(7, 8), 1'b1, h, inh);
        idle(10); chk("R9 zws no fill", 32'(fill_cnt), 32'(f0));
        wr_adr(la(6, 8));
        cmd(4'h6, 1'b1);
        idle(8);
        chk("R9 zws pin no fill", 32'(fill_cnt), 32'(f0));
        rd(1'b0, v); chk("R9 zws pin err2", v, 32'h9);

        // R4 machine check
        @(negedge clk); mce_type1 = 1'b1;
        @(negedge clk); mce_type1 = 1'b0;
        rd(1'b0, v); chk("R4 mce status", v, 32'h4);
        rd(1'b0, v); chk("R11 err1 cleared", v, 32'h0);
        acc(la(2, 3), 1'b0, h, inh);
        chk("R3 after mce", {30'd0, h, inh}, 32'd1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule